// File: doc/BRIEF.md
# Mask Register Right Shifter

This block is an execution unit that performs a logical right shift on 64-bit mask registers. It receives an instruction that has already been split into fields: an opcode byte, a width-select bit, a register-form ModRM byte and an 8-bit immediate count. The opcode byte and the width bit together choose an operand width of 8, 16, 32 or 64 bits. The unit reads the source mask register and shifts the low bits of that width right by the count, filling with zeros. It writes the result, zero-extended to 64 bits, to the destination mask register.

The unit holds an eight-entry mask register file. The file has a load port through which other execution units deposit mask values, and an asynchronous observation read port. Encodings that are not register-to-register forms, and opcode bytes outside the two supported values, are reported on a one-cycle illegal strobe and leave the register file untouched.

Top module: `mask_shr_unit`

## Requirements
- R1: The width is chosen from opcode byte and width bit: 0x31 with bit 1 gives 64 bits, 0x31 with bit 0 gives 32 bits, 0x30 with bit 1 gives 16 bits, and 0x30 with bit 0 gives 8 bits.
- R2: The count is the full 8-bit immediate, with no upper bits masked. A count of at least the selected width (for example 16 or 0x90 for the 16-bit form) writes all 64 destination bits as zero.
- R3: For a count below the width, the destination receives the source's low width bits shifted right by the count, with zero fill, and every bit from the width up to bit 63 cleared.
- R4: The destination index is ModRM bits [5:3] and the source index is ModRM bits [2:0]. An operation is legal only when ModRM bits [7:6] are 11b and the opcode byte is 0x30 or 0x31.
- R5: A strobed illegal operation raises `illegal` for exactly the cycle after the strobe, keeps `done` low and changes no register.
- R6: A strobed legal operation writes its destination at the next rising edge and raises `done` for exactly the cycle that follows that edge.
- R7: When source and destination indexes match, the shift uses the register value from before the write.
- R8: Reset (synchronous, active high) clears all eight registers and drives `done` and `illegal` low.
- R9: The load port writes `ld_data` into register `ld_idx` at the next rising edge. If a legal shift targets the same index at the same edge, the shift result is the value that is kept.
- R10: `obs_data` shows the register selected by `obs_idx` without a clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe starting one shift operation |
| opcode | input | 8 | Opcode byte (0x30 or 0x31 legal) |
| w_bit | input | 1 | Width-select bit |
| modrm | input | 8 | Register-form ModRM byte |
| imm | input | 8 | Shift count |
| ld_en | input | 1 | Load-port write enable |
| ld_idx | input | 3 | Load-port register index |
| ld_data | input | 64 | Load-port write data |
| obs_idx | input | 3 | Observation read index |
| obs_data | output | 64 | Observation read data |
| done | output | 1 | One-cycle strobe: destination written |
| illegal | output | 1 | One-cycle strobe: encoding rejected |

## Verification
The embedded properties check every cycle that `done` and `illegal` never rise together and only follow a strobe. They also check that a shift result computed for a legal strobe is zero above the chosen width, and fully zero when the count reaches the width. The exact shifted values, the register indexing, the old-value read when indexes match, the load/shift collision priority and the absence of writes after rejected encodings can only be shown by the bench's scenarios. The bench compares the whole register file against its own model after every operation.

// File: rtl/mask_shr_pkg.sv
package mask_shr_pkg;
  localparam int MASK_W     = 64;
  localparam int BASE_W     = 8;
  localparam int NUM_WIDTHS = 4;
  localparam int NUM_REGS   = 8;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int SEL_W      = $clog2(NUM_WIDTHS);
  localparam int CNT_W      = 8;

  typedef struct packed {
    logic             legal;
    logic [SEL_W-1:0] wsel;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
  } shr_dec_t;
endpackage

// File: rtl/mask_shr_decode.sv
module mask_shr_decode
  import mask_shr_pkg::*;
#(
  parameter logic [7:0] OPC_BASE = 8'h30
) (
  input  logic [7:0] opcode,
  input  logic       w_bit,
  input  logic [7:0] modrm,
  output shr_dec_t   dec
);
  localparam logic [1:0] REG_FORM = 2'b11;

  logic opc_hit;
  logic reg_form;

  always_comb begin
    opc_hit   = (opcode[7:1] == OPC_BASE[7:1]);
    reg_form  = (modrm[7:6] == REG_FORM);
    dec.legal = opc_hit && reg_form;
    // width index g selects BASE_W << g: low opcode bit is the upper index bit
    dec.wsel  = SEL_W'({opcode[0], w_bit});
    dec.dst   = modrm[3+IDX_W-1:3];
    dec.src   = modrm[IDX_W-1:0];
  end
endmodule

// File: rtl/mask_shr_shift.sv
module mask_shr_shift #(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8,
  parameter int NUM_W  = 4,
  parameter int CNT_W  = 8,
  localparam int SEL_W = $clog2(NUM_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] lane [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_lane
    localparam int LW = BASE_W << g;
    logic [DATA_W-1:0] ext;
    logic              in_range;
    always_comb begin
      ext      = DATA_W'(src[LW-1:0]);
      in_range = (32'(count) < LW);
      lane[g]  = in_range ? (ext >> count) : '0;
    end
  end

  always_comb res = lane[wsel];
endmodule

// File: rtl/mask_shr_regfile.sv
module mask_shr_regfile #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              sh_we,
  input  logic [IDX_W-1:0]  sh_idx,
  input  logic [DATA_W-1:0] sh_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  obs_idx,
  output logic [DATA_W-1:0] obs_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ld_we) mem[ld_idx] <= ld_data;
      // shift port is written last so it wins on a shared index (R9)
      if (sh_we) mem[sh_idx] <= sh_data;
    end
  end

  always_comb begin
    rd_data  = mem[rd_idx];
    obs_data = mem[obs_idx];
  end
endmodule

// File: rtl/mask_shr_unit.sv
module mask_shr_unit
  import mask_shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic              w_bit,
  input  logic [7:0]        modrm,
  input  logic [CNT_W-1:0]  imm,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [MASK_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  obs_idx,
  output logic [MASK_W-1:0] obs_data,
  output logic              done,
  output logic              illegal
);
  shr_dec_t          dec;
  logic [MASK_W-1:0] src_val;
  logic [MASK_W-1:0] shift_res;
  logic              do_write;
  logic              do_reject;

  mask_shr_decode #(.OPC_BASE(8'h30)) u_decode (
    .opcode (opcode),
    .w_bit  (w_bit),
    .modrm  (modrm),
    .dec    (dec)
  );

  mask_shr_shift #(
    .DATA_W (MASK_W),
    .BASE_W (BASE_W),
    .NUM_W  (NUM_WIDTHS),
    .CNT_W  (CNT_W)
  ) u_shift (
    .src   (src_val),
    .wsel  (dec.wsel),
    .count (imm),
    .res   (shift_res)
  );

  always_comb begin
    do_write  = in_valid && dec.legal;
    do_reject = in_valid && !dec.legal;
  end

  mask_shr_regfile #(
    .DATA_W (MASK_W),
    .DEPTH  (NUM_REGS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ld_we    (ld_en),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data),
    .sh_we    (do_write),
    .sh_idx   (dec.dst),
    .sh_data  (shift_res),
    .rd_idx   (dec.src),
    .rd_data  (src_val),
    .obs_idx  (obs_idx),
    .obs_data (obs_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= do_write;
      illegal <= do_reject;
    end
  end

  // R5
  done_illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal));

  // R6
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (done || illegal));

  // R5
  illegal_single_chk: assert property (@(posedge clk) disable iff (rst)
    (illegal && !$past(in_valid)) |-> 1'b0);

  // R3
  zero_above_width_chk: assert property (@(posedge clk) disable iff (rst)
    do_write |-> ((shift_res >> (32'(BASE_W) << dec.wsel)) == '0));

  // R2
  over_count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (do_write && (32'(imm) >= (32'(BASE_W) << dec.wsel))) |-> (shift_res == '0));
endmodule

// File: tb/test_mask_shr_unit.sv
module test_mask_shr_unit;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  opcode;
  logic        w_bit;
  logic [7:0]  modrm;
  logic [7:0]  imm;
  logic        ld_en;
  logic [2:0]  ld_idx;
  logic [63:0] ld_data;
  logic [2:0]  obs_idx;
  logic [63:0] obs_data;
  logic        done;
  logic        illegal;

  int total = 0;
  int bad   = 0;
  logic [63:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_shr_unit i_mask_shr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .w_bit(w_bit),
    .modrm(modrm), .imm(imm), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .obs_idx(obs_idx), .obs_data(obs_data), .done(done), .illegal(illegal)
  );

  function automatic logic [63:0] ref_shr(input logic [63:0] s, input int g,
                                          input logic [7:0] c);
    int w = 8 << g;
    logic [63:0] m;
    if (int'(c) >= w) return 64'd0;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (s & m) >> c;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    logic ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      obs_idx = 3'(i);
      #1;
      if (obs_data !== model[i]) begin
        ok = 1'b0;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, i, obs_data, model[i]);
      end
    end
    total++;
    if (!ok) bad++;
  endtask

  // drives one cycle of stimulus, checks strobes and whole register file
  task automatic step(input logic v, input logic [7:0] op, input logic wb,
                      input logic [7:0] mr, input logic [7:0] c,
                      input logic le, input logic [2:0] li, input logic [63:0] ld,
                      input string tag);
    logic legal;
    logic [63:0] res;
    legal = v && (op == 8'h30 || op == 8'h31) && (mr[7:6] == 2'b11);
    res = ref_shr(model[mr[2:0]], int'({op[0], wb}), c);
    in_valid = v; opcode = op; w_bit = wb; modrm = mr; imm = c;
    ld_en = le; ld_idx = li; ld_data = ld;
    @(posedge clk); #1;
    in_valid = 1'b0; ld_en = 1'b0;
    if (le) model[li] = ld;
    if (legal) model[mr[5:3]] = res;
    check({tag, " done"}, 64'(done), 64'(legal));
    check({tag, " illegal"}, 64'(illegal), 64'(v && !legal));
    check_regs(tag);
  endtask

  task automatic load(input logic [2:0] i, input logic [63:0] d);
    step(1'b0, 8'h0, 1'b0, 8'h0, 8'h0, 1'b1, i, d, "R9 load");
  endtask

  task automatic shr(input logic [7:0] op, input logic wb, input logic [2:0] dst,
                     input logic [2:0] src, input logic [7:0] c, input string tag);
    step(1'b1, op, wb, {2'b11, dst, src}, c, 1'b0, 3'd0, 64'd0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] pat = 64'hF0E1_D2C3_B4A5_9687;
    void'($urandom(32'h1BADF00D));
    rst = 1'b1; in_valid = 1'b0; opcode = 8'h0; w_bit = 1'b0; modrm = 8'h0;
    imm = 8'h0; ld_en = 1'b0; ld_idx = 3'd0; ld_data = 64'd0; obs_idx = 3'd0;
    for (int i = 0; i < 8; i++) model[i] = 64'd0;
    // dirty the file before reset takes effect
    @(posedge clk); #1;
    ld_en = 1'b1; ld_idx = 3'd4; ld_data = '1;
    repeat (3) @(posedge clk);
    #1; ld_en = 1'b0; rst = 1'b0;
    // R8 reset state
    check("R8 done", 64'(done), 64'd0);
    check("R8 illegal", 64'(illegal), 64'd0);
    check_regs("R8 regs");

    // R10 observation without clock: load then scan (scan inside step)
    for (int i = 0; i < 8; i++) load(3'(i), pat ^ (64'(i) * 64'h0101_0101_0101_0101));

    // R1 width decode, count 1
    shr(8'h30, 1'b0, 3'd0, 3'd1, 8'd1, "R1 8-bit");
    shr(8'h30, 1'b1, 3'd2, 3'd1, 8'd1, "R1 16-bit");
    shr(8'h31, 1'b0, 3'd3, 3'd1, 8'd1, "R1 32-bit");
    shr(8'h31, 1'b1, 3'd4, 3'd1, 8'd1, "R1 64-bit");
    // R3 edges: count 0 and width-1
    shr(8'h30, 1'b0, 3'd0, 3'd5, 8'd0, "R3 8-bit count0");
    shr(8'h30, 1'b0, 3'd0, 3'd5, 8'd7, "R3 8-bit count7");
    shr(8'h31, 1'b1, 3'd0, 3'd5, 8'd63, "R3 64-bit count63");
    shr(8'h31, 1'b0, 3'd2, 3'd5, 8'd31, "R3 32-bit count31");
    // R2 over-count clears, full imm used
    load(3'd6, '1);
    shr(8'h30, 1'b1, 3'd6, 3'd5, 8'd16, "R2 16-bit count16");
    load(3'd6, '1);
    shr(8'h30, 1'b0, 3'd6, 3'd5, 8'd8, "R2 8-bit count8");
    load(3'd6, '1);
    shr(8'h31, 1'b1, 3'd6, 3'd5, 8'd64, "R2 64-bit count64");
    load(3'd6, '1);
    shr(8'h30, 1'b1, 3'd6, 3'd5, 8'h90, "R2 16-bit count0x90");
    load(3'd6, '1);
    shr(8'h31, 1'b1, 3'd6, 3'd5, 8'hFF, "R2 64-bit count255");
    // R7 same index uses old value
    load(3'd7, 64'h8000_0000_0000_0001);
    shr(8'h31, 1'b1, 3'd7, 3'd7, 8'd3, "R7 in-place");
    // R5 illegal: bad mod, bad opcode
    step(1'b1, 8'h31, 1'b1, 8'b10_001_010, 8'd1, 1'b0, 3'd0, 64'd0, "R5 mod10");
    step(1'b1, 8'h32, 1'b0, 8'b11_001_010, 8'd1, 1'b0, 3'd0, 64'd0, "R5 opc32");
    step(1'b1, 8'hB0, 1'b0, 8'b11_001_010, 8'd1, 1'b0, 3'd0, 64'd0, "R5 opcB0");
    // R6 pulse width: idle cycle after op
    shr(8'h31, 1'b0, 3'd1, 3'd2, 8'd4, "R6 op");
    step(1'b0, 8'h31, 1'b0, 8'hC0, 8'd0, 1'b0, 3'd0, 64'd0, "R6 idle");
    // R9 collision: same index, shift wins; distinct indexes both written
    step(1'b1, 8'h31, 1'b1, {2'b11, 3'd3, 3'd0}, 8'd2, 1'b1, 3'd3, 64'hDEAD, "R9 same idx");
    step(1'b1, 8'h31, 1'b1, {2'b11, 3'd3, 3'd0}, 8'd2, 1'b1, 3'd5, 64'hBEEF, "R9 diff idx");
    // R4 index mapping: every dst/src pairing sample
    for (int d = 0; d < 8; d++)
      shr(8'h30, 1'b1, 3'(d), 3'(7 - d), 8'(d), "R4 index map");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op, mr, c;
      logic wb, v, le;
      int r = int'($urandom_range(0, 9));
      op = (r == 0) ? 8'($urandom) : ((r < 5) ? 8'h30 : 8'h31);
      mr = 8'($urandom);
      if ($urandom_range(0, 5) != 0) mr[7:6] = 2'b11;
      c  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 70));
      wb = 1'($urandom);
      v  = ($urandom_range(0, 4) != 0);
      le = ($urandom_range(0, 2) == 0);
      step(v, op, wb, mr, c, le, 3'($urandom), {32'($urandom), 32'($urandom)},
           "R3 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule